// File: doc/BRIEF.md
# SPI Bus Event Trigger

This block watches an SPI bus without driving it. SCLK, MOSI, MISO and the slave select reach it already synchronized to the system clock. It raises a single-cycle trigger pulse when the selected event occurs. There are three events. The first is the select line entering its active level. The second is the opening of a frame on a bus with no select line, where a clock edge after a long enough quiet period marks the frame. The third is a run of consecutive received words that matches a pattern in which any bit may be marked don't-care.

All settings are static inputs. They cover clock idle level and sampling phase, select polarity and whether the select is used for framing, word length, idle threshold, which data line is compared, the trigger kind, the number of pattern words, and the pattern with its per-bit care mask. Change the settings only while the block is held in reset, because changing the clock idle level produces an edge on the bus. The block is meant to sit behind a capture buffer as its trigger source.

Top module: `spi_frame_trigger`

## Requirements
- R1: `trig` is 0 while `rst_n` is low and stays 0 while the bus is quiet after reset.
- R2: With `cfg_event`=0, `ss` changing from its inactive level to its active level gives exactly one `trig` pulse, in the cycle after the change. The active level is high when `cfg_ss_high`=1 and low when it is 0. Leaving the active level gives no pulse.
- R3: With `cfg_event`=1, an SCLK edge gives a one-cycle `trig` in the following cycle when it arrives more than `cfg_idle` system clocks after the previous SCLK edge. The first edge after reset also counts.
- R4: A data bit is taken on the rising SCLK edge when `cfg_cpol` equals `cfg_cpha`, and on the falling edge otherwise.
- R5: Both data lines are sampled on every sampling edge. `cfg_src`=0 compares MOSI and `cfg_src`=1 compares MISO. A match on the other line has no effect.
- R6: Words are `cfg_len` bits long, legal from 4 to 32, and are received MSB first.
- R7: Pattern word k sits at `cfg_pat[32k +: 32]`, using its low `cfg_len` bits. A `cfg_care` bit of 1 means the bit is compared and 0 means don't-care. With `cfg_event`=2, the trigger needs the last `cfg_nwords` words of the current frame to equal pattern words 0, 1, … in order. A value of 0 for `cfg_nwords` acts as 1, and values above 4 act as 4. Matches may slide: earlier non-matching words in the frame do not block a match.
- R8: A data trigger shows two cycles after the cycle in which the sampling edge of the word's last bit is seen: one cycle to compare and one registered output stage.
- R9: When `cfg_ss_used`=1, bits are taken only while select is active, and each select activation opens a frame. When it is 0, the edge that satisfies R3 opens a frame. Opening a frame discards any partial word and all earlier matched words.
- R10: When the edge that opens a frame is also a sampling edge, its bit is the first bit of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Synchronized bus clock |
| mosi | input | 1 | Synchronized controller-to-peripheral data |
| miso | input | 1 | Synchronized peripheral-to-controller data |
| ss | input | 1 | Synchronized slave select |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_ss_high | input | 1 | 1: select active high |
| cfg_ss_used | input | 1 | 1: frames come from select, 0: from idle timeout |
| cfg_len | input | 6 | Word length in bits, 4..32 |
| cfg_idle | input | 16 | Idle threshold in system clocks |
| cfg_src | input | 1 | 0: MOSI, 1: MISO |
| cfg_event | input | 2 | 0 select, 1 idle frame start, 2 data, 3 none |
| cfg_nwords | input | 3 | Pattern words, 1..4 |
| cfg_pat | input | 128 | Pattern words, word 0 in the low 32 bits |
| cfg_care | input | 128 | Per-bit compare enable |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
A frame opening and a sampling edge can land in the same cycle. This happens in idle-timeout framing with a leading-edge phase: the first edge after a quiet gap both opens the frame and carries a data bit. The bench provokes it by leaving a partial word on the bus, waiting past the threshold, and then sending the pattern. The trigger must fire at the time R8 gives, which shows that the stale bits were dropped and the opening edge's bit was kept. A behavioural model that keeps queues of bits and words is compared with `trig` on every clock.

// File: rtl/spi_frame_trigger.sv
module spi_frame_trigger #(
  parameter int MAXW = 32,
  parameter int NW = 4,
  parameter int IDW = 16,
  localparam int LW = $clog2(MAXW + 1),
  localparam int NWW = $clog2(NW + 1),
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             mosi,
  input  logic             miso,
  input  logic             ss,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_ss_high,
  input  logic             cfg_ss_used,
  input  logic [LW-1:0]    cfg_len,
  input  logic [IDW-1:0]   cfg_idle,
  input  logic             cfg_src,
  input  logic [1:0]       cfg_event,
  input  logic [NWW-1:0]   cfg_nwords,
  input  logic [NW*MAXW-1:0] cfg_pat,
  input  logic [NW*MAXW-1:0] cfg_care,
  output logic             trig
);

  logic           sclk_q, act_q, done;
  logic [IDW-1:0] idle_cnt;
  logic [LW-1:0]  bcnt;
  logic [MAXW-1:0] sh, lmask;
  logic [NW-1:0]  chain, chain_n, hit;
  logic [IW-1:0]  nidx;
  logic           evt;

  wire act        = (ss == cfg_ss_high);
  wire sck_edge   = sclk ^ sclk_q;
  wire sel_start  = act & ~act_q;
  wire idle_start = sck_edge & (idle_cnt >= cfg_idle);
  wire fs         = cfg_ss_used ? sel_start : idle_start;
  wire smp        = sck_edge & (sclk == ~(cfg_cpol ^ cfg_cpha)) & (act | ~cfg_ss_used);
  wire din        = cfg_src ? miso : mosi;
  wire [LW-1:0] base = fs ? '0 : bcnt;
  wire last       = (base + 1'b1) == cfg_len;

  always_comb begin
    for (int i = 0; i < MAXW; i++) lmask[i] = (i < int'(cfg_len));
  end

  for (genvar k = 0; k < NW; k++) begin : g_word
    assign hit[k] = ~|((sh ^ cfg_pat[k*MAXW +: MAXW]) & cfg_care[k*MAXW +: MAXW] & lmask);
    if (k == 0) begin : g_first
      assign chain_n[k] = hit[k];
    end else begin : g_next
      assign chain_n[k] = chain[k-1] & hit[k];
    end
  end

  always_comb begin
    if (cfg_nwords == '0) nidx = '0;
    else if (int'(cfg_nwords) > NW) nidx = IW'(NW - 1);
    else nidx = IW'(cfg_nwords - 1'b1);
  end

  wire data_hit = done & chain_n[nidx];

  always_comb begin
    case (cfg_event)
      2'd0: evt = sel_start;
      2'd1: evt = idle_start;
      2'd2: evt = data_hit;
      default: evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= cfg_cpol;
      act_q    <= 1'b1;
      idle_cnt <= '1;
      bcnt     <= '0;
      sh       <= '0;
      done     <= 1'b0;
      chain    <= '0;
      trig     <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      act_q    <= act;
      idle_cnt <= sck_edge ? '0 : (&idle_cnt ? idle_cnt : idle_cnt + 1'b1);
      done     <= smp & last;
      if (smp) begin
        sh   <= {sh[MAXW-2:0], din};
        bcnt <= last ? '0 : base + 1'b1;
      end else if (fs) begin
        bcnt <= '0;
      end
      if (fs) chain <= '0;
      else if (done) chain <= chain_n;
      trig <= evt;
    end
  end

endmodule

// File: rtl/spi_frame_trigger_chk.sv
module spi_frame_trigger_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       sclk_q,
  input logic       ss,
  input logic       cfg_ss_high,
  input logic [1:0] cfg_event,
  input logic       done,
  input logic       trig
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !trig);

  p_sel_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(cfg_event) == 2'd0) |-> $past(ss == cfg_ss_high));

  p_sel_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(cfg_event) == 2'd0) |=> !trig);

  p_idle_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(cfg_event) == 2'd1) |-> ($past(sclk) != $past(sclk_q)));

  p_word_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(cfg_event) == 2'd2) |-> $past(done));

  p_done_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(sclk) != $past(sclk_q)));

endmodule

bind spi_frame_trigger spi_frame_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sclk_q(sclk_q), .ss(ss),
  .cfg_ss_high(cfg_ss_high), .cfg_event(cfg_event), .done(done), .trig(trig)
);

// File: tb/sim_spi_frame_trigger.sv
module sim_spi_frame_trigger;
  localparam int H = 2;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, mosi = 0, miso = 0, ss = 1;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_ss_high = 0, cfg_ss_used = 1;
  logic [5:0] cfg_len = 6'd8;
  logic [15:0] cfg_idle = 16'd10;
  logic cfg_src = 0;
  logic [1:0] cfg_event = 2'd3;
  logic [2:0] cfg_nwords = 3'd1;
  logic [127:0] cfg_pat = '0, cfg_care = '0;
  logic trig;

  int n_tests = 0, n_fail = 0, pulses = 0;
  string tag = "R1";
  logic exp_trig = 0;

  always #2 clk = ~clk;

  spi_frame_trigger u0 (.*);

  // behavioural reference
  logic m_prev_sclk, m_prev_act, pend;
  int m_idle, nb;
  logic [31:0] cur, pend_w;
  logic [31:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_sclk = cfg_cpol; m_prev_act = 1; m_idle = 65535;
      nb = 0; cur = 0; pend = 0; hist.delete(); exp_trig = 0;
    end else begin
      logic act, edg, selst, idlest, fs, samp, dhit, d;
      logic [31:0] lm;
      int n, sz;
      act = (ss == cfg_ss_high);
      edg = (sclk != m_prev_sclk);
      selst = act && !m_prev_act;
      idlest = edg && (m_idle >= int'(cfg_idle));
      fs = cfg_ss_used ? selst : idlest;
      samp = edg && (sclk == ~(cfg_cpol ^ cfg_cpha)) && (act || !cfg_ss_used);
      d = cfg_src ? miso : mosi;
      lm = (cfg_len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << cfg_len) - 1);
      n = (cfg_nwords == 0) ? 1 : (cfg_nwords > 4 ? 4 : int'(cfg_nwords));
      dhit = 0;
      if (pend) begin
        hist.push_back(pend_w);
        pend = 0;
        sz = hist.size();
        if (sz >= n) begin
          dhit = 1;
          for (int i = 0; i < n; i++)
            if (((hist[sz-n+i] ^ cfg_pat[i*32 +: 32]) & cfg_care[i*32 +: 32] & lm) != 0) dhit = 0;
        end
      end
      if (fs) begin hist.delete(); cur = 0; nb = 0; end
      if (samp) begin
        cur = (cur << 1) | {31'd0, d};
        nb++;
        if (nb == int'(cfg_len)) begin pend = 1; pend_w = cur; cur = 0; nb = 0; end
      end
      m_idle = edg ? 0 : (m_idle < 65535 ? m_idle + 1 : m_idle);
      m_prev_sclk = sclk; m_prev_act = act;
      exp_trig = (cfg_event == 0 && selst) || (cfg_event == 1 && idlest) || (cfg_event == 2 && dhit);
    end
  end

  always @(negedge clk) begin
    n_tests++;
    if (trig !== exp_trig) begin
      n_fail++;
      $display("FAIL %s per-cycle trig=%0b expected %0b at %0t", tag, trig, exp_trig, $time);
    end
    if (trig) pulses++;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic restart(logic cpol, logic cpha);
    @(negedge clk);
    rst_n = 0; cfg_cpol = cpol; cfg_cpha = cpha; sclk = cpol;
    ss = ~cfg_ss_high;
    tick(3); rst_n = 1; tick(2); pulses = 0;
  endtask

  task automatic xfer(int nbits, logic [31:0] mo, logic [31:0] mi);
    for (int i = nbits - 1; i >= 0; i--) begin
      if (!cfg_cpha) begin
        mosi = mo[i]; miso = mi[i]; tick(H); sclk = ~sclk; tick(H); sclk = ~sclk;
      end else begin
        sclk = ~sclk; mosi = mo[i]; miso = mi[i]; tick(H); sclk = ~sclk; tick(H);
      end
    end
    tick(H);
  endtask

  task automatic frame(int nbits, logic [31:0] mo, logic [31:0] mi);
    if (cfg_ss_used) begin ss = cfg_ss_high; tick(2); end
    xfer(nbits, mo, mi);
    if (cfg_ss_used) begin ss = ~cfg_ss_high; end
    tick(6);
  endtask

  task automatic expect_pulses(string req, int expn);
    tick(4); check(req, pulses, expn); pulses = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1
    tag = "R1"; cfg_event = 2'd0;
    tick(1); check("R1 trig in reset", trig, 0);
    restart(0, 0); tick(20); check("R1 quiet after reset", pulses, 0);

    // R2 active low then active high
    tag = "R2"; cfg_ss_high = 0; cfg_ss_used = 1; restart(0, 0);
    ss = 0; tick(1); check("R2 pulse next cycle", trig, 1);
    tick(1); check("R2 single cycle", trig, 0);
    tick(5); ss = 1; expect_pulses("R2 deassert active-low", 1);
    cfg_ss_high = 1; restart(0, 0);
    ss = 1; tick(5); ss = 0; expect_pulses("R2 active-high", 1);

    // R3 idle framing
    tag = "R3"; cfg_event = 2'd1; cfg_ss_used = 0; cfg_idle = 10; restart(0, 0);
    xfer(8, 32'h5A, 0); tick(40); xfer(8, 32'h3C, 0);
    expect_pulses("R3 two frames after idle", 2);

    // R4 R5 R6 R8 data trigger, select framing
    tag = "R8"; cfg_event = 2'd2; cfg_ss_used = 1; cfg_ss_high = 0; cfg_len = 8;
    cfg_nwords = 1; cfg_pat = 128'hA5; cfg_care = 128'hFF; cfg_src = 0;
    restart(0, 0);
    frame(8, 32'hA5, 32'h00); expect_pulses("R6 R8 MOSI match mode0", 1);
    tag = "R5";
    frame(8, 32'h5A, 32'hA5); expect_pulses("R5 MISO ignored when MOSI selected", 0);
    cfg_src = 1;
    frame(8, 32'h5A, 32'hA5); expect_pulses("R5 MISO selected", 1);
    cfg_src = 0; tag = "R4";
    restart(0, 1); frame(8, 32'hA5, 0); expect_pulses("R4 mode1", 1);
    restart(1, 0); frame(8, 32'hA5, 0); expect_pulses("R4 mode2", 1);
    restart(1, 1); frame(8, 32'hA5, 0); expect_pulses("R4 mode3", 1);
    frame(8, 32'hA4, 0); expect_pulses("R4 mode3 mismatch", 0);

    // R7 multi-word 24-bit with don't-care nibble on MISO
    tag = "R7"; cfg_len = 24; cfg_nwords = 2; cfg_src = 1;
    cfg_pat = {64'd0, 32'h00ABC0EF, 32'h00123456};
    cfg_care = {64'd0, 32'h00FFF0FF, 32'h00FFFFFF};
    restart(0, 0);
    ss = 0; tick(2); xfer(24, 0, 32'h123456); xfer(24, 0, 32'hABCDEF); ss = 1; tick(6);
    expect_pulses("R7 two words masked nibble", 1);
    ss = 0; tick(2); xfer(24, 0, 32'h999999); xfer(24, 0, 32'h123456); xfer(24, 0, 32'hABC7EF); ss = 1; tick(6);
    expect_pulses("R7 sliding match", 1);
    ss = 0; tick(2); xfer(24, 0, 32'hABCDEF); xfer(24, 0, 32'h123456); ss = 1; tick(6);
    expect_pulses("R7 wrong order", 0);
    ss = 0; tick(2); xfer(24, 0, 32'h123456); ss = 1; tick(4);
    ss = 0; tick(2); xfer(24, 0, 32'hABCDEF); ss = 1; tick(6);
    expect_pulses("R9 history dropped across frames", 0);

    // R9 abort partial word in select framing
    tag = "R9"; cfg_len = 8; cfg_nwords = 1; cfg_src = 0;
    cfg_pat = 128'hA5; cfg_care = 128'hFF; restart(0, 0);
    ss = 0; tick(2); xfer(5, 32'h1F, 0); ss = 1; tick(4);
    xfer(3, 32'h7, 0);
    ss = 0; tick(2); xfer(8, 32'hA5, 0); ss = 1; tick(6);
    expect_pulses("R9 partial word and idle bits discarded", 1);

    // R10 idle framing, opening edge carries first bit
    tag = "R10"; cfg_ss_used = 0; cfg_idle = 10; restart(0, 0);
    xfer(3, 32'h5, 0); tick(40); xfer(8, 32'hA5, 0); tick(6);
    expect_pulses("R10 opening edge is first bit", 1);

    // R6 length bounds
    tag = "R6"; cfg_ss_used = 1; cfg_len = 4; cfg_pat = 128'h9; cfg_care = 128'hF;
    restart(0, 0); frame(4, 32'h9, 0); expect_pulses("R6 4-bit word", 1);
    cfg_len = 32; cfg_pat = 128'hDEADBEEF; cfg_care = 128'hFFFFFFFF;
    restart(0, 0); frame(32, 32'hDEADBEEF, 0); expect_pulses("R6 32-bit word", 1);
    frame(32, 32'hDEADBEEE, 0); expect_pulses("R6 32-bit mismatch", 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule